// File: doc/BRIEF.md
# UART Receive Queue with Line Error Tracking

This block sits between a UART deserializer and the register interface. Each received character is stored as a byte plus three flags: parity error, framing error and break. The stored entries form a sixteen-deep first-in first-out queue. The oldest entry is always presented at the outputs, together with its own flags. A read strobe from the data register removes that entry.

Around the queue the block keeps the receive-side status. A data-ready bit is set whenever the queue is not empty. A sticky overrun bit records characters lost to a full queue. A sticky any-error bit tracks flagged entries, and both sticky bits respond to a line status read. The block also compares the occupancy against a programmable trigger level to raise a data-available indication. It drives a request-to-send output for hardware flow control and can empty the queue on request.

Top module: `uart_rx_queue`

## Requirements
- R1: `data_ready_o` is 1 exactly when the queue holds at least one entry. `head_data_o` shows the oldest stored byte, and entries leave in arrival order. The queue holds up to 16 entries.
- R2: `trig_code_i` values 0, 1, 2 and 3 select a level of 1, 4, 8 and 14 entries. `trig_hit_o` is 1 exactly when the occupancy is at or above the selected level.
- R3: A character (`rx_valid_i`=1) that arrives while the queue is full, with no pop in the same cycle, is discarded and sets `overrun_o` at the next edge. A line status read (`lsr_rd_i`) clears `overrun_o`; a new discard in the same cycle wins.
- R4: `head_perr_o`, `head_ferr_o` and `head_brk_o` equal the flags stored with the head entry (inputs `rx_perr_i`, `rx_ferr_i` and `rx_brk_i` at arrival). All three are 0 when the queue is empty.
- R5: `any_err_o` is set when an entry carrying any flag is stored. A line status read clears it only if no flagged entry is stored at that read. A queue reset also clears it.
- R6: With `rts_force_i`=0, `rts_o` is 0 from the next edge on. With `rts_force_i`=1 and `afc_en_i`=0, `rts_o` is 1. With both set, each edge sets `rts_o` to 1 if the occupancy is below the trigger level. Otherwise the edge sets it to 0 if `start_seen_i` is 1, and holds it if not.
- R7: A pulse on `fifo_clr_i` raises `clr_pend_o` at the next edge. The edge after that empties the queue and drops `clr_pend_o`. A character offered in that cycle is dropped and does not set `overrun_o`.
- R8: A push together with a pop leaves the occupancy unchanged, even when the queue is full, and sets no overrun. A pop (`data_rd_i`) on an empty queue is ignored.
- R9: After reset the queue is empty. `data_ready_o`, `overrun_o`, `any_err_o`, `clr_pend_o`, `trig_hit_o` and `rts_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | Character received strobe |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error flag of the received byte |
| rx_ferr_i | input | 1 | Framing error flag of the received byte |
| rx_brk_i | input | 1 | Break flag of the received byte |
| start_seen_i | input | 1 | Start bit detected strobe |
| data_rd_i | input | 1 | Data register read strobe (pop) |
| lsr_rd_i | input | 1 | Line status read strobe |
| fifo_clr_i | input | 1 | Queue reset request |
| trig_code_i | input | 2 | Trigger level code |
| afc_en_i | input | 1 | Automatic flow control enable |
| rts_force_i | input | 1 | Software request-to-send enable |
| head_data_o | output | 8 | Byte at the head of the queue |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun status |
| head_perr_o | output | 1 | Parity error of the head entry |
| head_ferr_o | output | 1 | Framing error of the head entry |
| head_brk_o | output | 1 | Break flag of the head entry |
| any_err_o | output | 1 | Sticky any-error status |
| clr_pend_o | output | 1 | Queue reset request pending |
| trig_hit_o | output | 1 | Occupancy at or above trigger level |
| rts_o | output | 1 | Request-to-send (1 = asserted) |

## Verification
Several input patterns are used, each to tell apart a different class of fault. A vector table interleaves clean and flagged characters with pops and a simultaneous push and pop at level 4. This shows whether the flags travel with their own byte rather than with the newest one, and whether the trigger follows the occupancy in both directions. Directed runs fill the queue to 16 and then offer a seventeenth byte, which separates a correct discard from an overwrite. A simultaneous push and pop on the full queue shows whether the occupancy is counted correctly there and whether overrun is wrongly set. Other runs step the occupancy across each trigger boundary, hold a flagged entry across a status read, and walk the flow-control output through hold, start-bit drop and recovery.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [BYTE_W-1:0] data;
    } rxq_entry_t;

    function automatic logic entry_flagged(input rxq_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push_req,
    input  rxq_entry_t    wr_entry,
    input  logic          pop_req,
    output logic          push_acc,
    output logic          pop_acc,
    output logic          drop,
    output logic [CW-1:0] count,
    output rxq_entry_t    head
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxq_entry_t    slot [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign pop_acc  = pop_req & (count != '0) & ~clr;
    assign push_acc = push_req & ~clr & ((count < CW'(DEPTH)) | pop_acc);
    assign drop     = push_req & ~clr & ~push_acc;
    assign head     = slot[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_acc && wr_ptr == AW'(i)) begin
                slot[i] <= wr_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= bump(wr_ptr);
            if (pop_acc)  rd_ptr <= bump(rd_ptr);
            if (push_acc && !pop_acc)      count <= count + 1'b1;
            else if (pop_acc && !push_acc) count <= count - 1'b1;
        end
    end

    // R8: push and pop together keep the occupancy
    a_r8_pushpop_steady: assert property (@(posedge clk) disable iff (rst)
        (push_acc && pop_acc) |=> (count == $past(count)));

    // R3: a discarded character leaves the queue full
    a_r3_full_no_grow: assert property (@(posedge clk) disable iff (rst)
        drop |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/uart_rxq_errs.sv
module uart_rxq_errs #(
    parameter int unsigned CW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push_acc,
    input  logic push_flag,
    input  logic pop_acc,
    input  logic pop_flag,
    input  logic drop,
    input  logic lsr_rd,
    output logic overrun,
    output logic any_err
);
    logic [CW-1:0] err_cnt;
    logic          add_err, sub_err;

    assign add_err = push_acc & push_flag;
    assign sub_err = pop_acc & pop_flag;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_cnt <= '0;
        end else if (add_err && !sub_err) begin
            err_cnt <= err_cnt + 1'b1;
        end else if (sub_err && !add_err) begin
            err_cnt <= err_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (lsr_rd) begin
            overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            any_err <= 1'b0;
        end else if (add_err) begin
            any_err <= 1'b1;
        end else if (lsr_rd && err_cnt == '0) begin
            any_err <= 1'b0;
        end
    end

    // R3: a discard always shows as overrun
    a_r3_ovr_set: assert property (@(posedge clk) disable iff (rst)
        drop |=> overrun);

    // R5: the error bit survives while flagged entries remain
    a_r5_err_hold: assert property (@(posedge clk) disable iff (rst)
        (any_err && err_cnt != '0 && !clr) |=> any_err);

endmodule

// File: rtl/uart_rxq_flow.sv
module uart_rxq_flow
    import uart_rxq_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [1:0]    trig_code,
    input  logic          afc_en,
    input  logic          rts_force,
    input  logic          start_seen,
    output logic          trig_hit,
    output logic          rts
);
    logic [CW-1:0] level;

    assign level    = CW'(trig_level(trig_code));
    assign trig_hit = (count >= level);

    always_ff @(posedge clk) begin
        if (rst || !rts_force) begin
            rts <= 1'b0;
        end else if (!afc_en || !trig_hit) begin
            rts <= 1'b1;
        end else if (start_seen) begin
            rts <= 1'b0;
        end
    end

    // R6: no request-to-send without the software enable
    a_r6_forced_off: assert property (@(posedge clk) disable iff (rst)
        !rts_force |=> !rts);

    // R6: a start bit at or above the level drops the request
    a_r6_start_drop: assert property (@(posedge clk) disable iff (rst)
        (rts_force && afc_en && trig_hit && start_seen) |=> !rts);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              rx_brk_i,
    input  logic              start_seen_i,
    input  logic              data_rd_i,
    input  logic              lsr_rd_i,
    input  logic              fifo_clr_i,
    input  logic [1:0]        trig_code_i,
    input  logic              afc_en_i,
    input  logic              rts_force_i,
    output logic [BYTE_W-1:0] head_data_o,
    output logic              data_ready_o,
    output logic              overrun_o,
    output logic              head_perr_o,
    output logic              head_ferr_o,
    output logic              head_brk_o,
    output logic              any_err_o,
    output logic              clr_pend_o,
    output logic              trig_hit_o,
    output logic              rts_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rxq_entry_t    in_entry, head;
    logic          push_acc, pop_acc, drop;
    logic [CW-1:0] count;
    logic          clr_pend;

    assign in_entry = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_pend <= 1'b0;
        end else if (fifo_clr_i) begin
            clr_pend <= 1'b1;
        end else begin
            clr_pend <= 1'b0;
        end
    end

    uart_rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_pend),
        .push_req (rx_valid_i),
        .wr_entry (in_entry),
        .pop_req  (data_rd_i),
        .push_acc (push_acc),
        .pop_acc  (pop_acc),
        .drop     (drop),
        .count    (count),
        .head     (head)
    );

    uart_rxq_errs #(.CW(CW)) u_errs (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_pend),
        .push_acc  (push_acc),
        .push_flag (entry_flagged(in_entry)),
        .pop_acc   (pop_acc),
        .pop_flag  (entry_flagged(head)),
        .drop      (drop),
        .lsr_rd    (lsr_rd_i),
        .overrun   (overrun_o),
        .any_err   (any_err_o)
    );

    uart_rxq_flow #(.CW(CW)) u_flow (
        .clk        (clk),
        .rst        (rst),
        .count      (count),
        .trig_code  (trig_code_i),
        .afc_en     (afc_en_i),
        .rts_force  (rts_force_i),
        .start_seen (start_seen_i),
        .trig_hit   (trig_hit_o),
        .rts        (rts_o)
    );

    assign data_ready_o = (count != '0);
    assign head_data_o  = head.data;
    assign head_perr_o  = data_ready_o & head.perr;
    assign head_ferr_o  = data_ready_o & head.ferr;
    assign head_brk_o   = data_ready_o & head.brk;
    assign clr_pend_o   = clr_pend;

    // R7: a pending clear leaves the queue empty one edge later
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr_pend |=> !data_ready_o);

    // R4: no head flags on an empty queue
    a_r4_empty_flags: assert property (@(posedge clk) disable iff (rst)
        !data_ready_o |-> !(head_perr_o || head_ferr_o || head_brk_o));

endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_data = '0;
    logic       start_seen = 0, data_rd = 0, lsr_rd = 0, fifo_clr = 0;
    logic [1:0] trig_code = 2'd1;
    logic       afc_en = 0, rts_force = 0;
    logic [7:0] head_data;
    logic       data_ready, overrun, head_perr, head_ferr, head_brk;
    logic       any_err, clr_pend, trig_hit, rts;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst(rst),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk),
        .start_seen_i(start_seen), .data_rd_i(data_rd), .lsr_rd_i(lsr_rd),
        .fifo_clr_i(fifo_clr), .trig_code_i(trig_code),
        .afc_en_i(afc_en), .rts_force_i(rts_force),
        .head_data_o(head_data), .data_ready_o(data_ready), .overrun_o(overrun),
        .head_perr_o(head_perr), .head_ferr_o(head_ferr), .head_brk_o(head_brk),
        .any_err_o(any_err), .clr_pend_o(clr_pend),
        .trig_hit_o(trig_hit), .rts_o(rts)
    );

    // flags field order: {brk, ferr, perr}
    typedef struct packed {
        logic       push;
        logic [7:0] d;
        logic [2:0] f;
        logic       pop;
        logic       dr;
        logic [7:0] hd;
        logic [2:0] hf;
        logic       trig;
        logic       err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA1, 3'b000, 1'b0, 1'b1, 8'hA1, 3'b000, 1'b0, 1'b0},
        '{1'b1, 8'hB2, 3'b001, 1'b0, 1'b1, 8'hA1, 3'b000, 1'b0, 1'b1},
        '{1'b1, 8'hC3, 3'b010, 1'b0, 1'b1, 8'hA1, 3'b000, 1'b0, 1'b1},
        '{1'b1, 8'hD4, 3'b000, 1'b0, 1'b1, 8'hA1, 3'b000, 1'b1, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 8'hB2, 3'b001, 1'b0, 1'b1},
        '{1'b1, 8'hE5, 3'b100, 1'b1, 1'b1, 8'hC3, 3'b010, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 8'hD4, 3'b000, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 8'hE5, 3'b100, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        start_seen = 0; data_rd = 0; lsr_rd = 0; fifo_clr = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = f;
        tick();
    endtask

    task automatic pop();
        data_rd = 1;
        tick();
    endtask

    task automatic clear_q();
        fifo_clr = 1;
        tick();
        tick();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9: reset state
        chk("R9", "data_ready", data_ready, 0);
        chk("R9", "overrun", overrun, 0);
        chk("R9", "any_err", any_err, 0);
        chk("R9", "clr_pend", clr_pend, 0);
        chk("R9", "trig_hit", trig_hit, 0);
        chk("R9", "rts", rts, 0);

        // R1 R2 R4 R5 R8: vector table at trigger level 4
        for (int i = 0; i < NV; i++) begin
            rx_valid = VECS[i].push; rx_data = VECS[i].d;
            {rx_brk, rx_ferr, rx_perr} = VECS[i].f;
            data_rd = VECS[i].pop;
            tick();
            chk("R1", $sformatf("vec%0d data_ready", i), data_ready, VECS[i].dr);
            if (VECS[i].dr) chk("R1", $sformatf("vec%0d head", i), head_data, VECS[i].hd);
            chk("R4", $sformatf("vec%0d flags", i), {head_brk, head_ferr, head_perr}, VECS[i].hf);
            chk("R2", $sformatf("vec%0d trig", i), trig_hit, VECS[i].trig);
            chk("R5", $sformatf("vec%0d any_err", i), any_err, VECS[i].err);
        end
        lsr_rd = 1; tick();
        chk("R5", "cleared with no flagged entry", any_err, 0);

        // R8: pop on empty ignored
        pop();
        chk("R8", "empty pop data_ready", data_ready, 0);
        push(8'h3C, 3'b000);
        chk("R8", "head after empty pop", head_data, 8'h3C);
        pop();
        chk("R8", "single entry only", data_ready, 0);

        // R5: clear guarded by stored flagged entry
        push(8'h5A, 3'b001);
        lsr_rd = 1; tick();
        chk("R5", "held with flagged entry", any_err, 1);
        pop();
        lsr_rd = 1; tick();
        chk("R5", "cleared after pop", any_err, 0);

        // R3 R8: full queue
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 3'b000);
        chk("R3", "no overrun at 16", overrun, 0);
        push(8'hEE, 3'b000);
        chk("R3", "overrun set", overrun, 1);
        chk("R3", "head kept", head_data, 8'h10);
        lsr_rd = 1; tick();
        chk("R3", "overrun cleared", overrun, 0);
        rx_valid = 1; rx_data = 8'h77; data_rd = 1; tick();
        chk("R8", "full push+pop no overrun", overrun, 0);
        chk("R8", "full push+pop head", head_data, 8'h11);
        for (int i = 0; i < 15; i++) pop();
        chk("R1", "order kept, last byte", head_data, 8'h77);
        chk("R1", "one left", data_ready, 1);
        pop();
        chk("R1", "sixteen drained", data_ready, 0);

        // R7: queue reset
        push(8'h01, 3'b100);
        push(8'h02, 3'b000);
        fifo_clr = 1; tick();
        chk("R7", "pending raised", clr_pend, 1);
        chk("R7", "not yet empty", data_ready, 1);
        push(8'h99, 3'b000);
        chk("R7", "pending dropped", clr_pend, 0);
        chk("R7", "emptied and push dropped", data_ready, 0);
        chk("R7", "no overrun from dropped push", overrun, 0);
        chk("R5", "cleared by queue reset", any_err, 0);

        // R2: trigger boundaries
        trig_code = 2'd0;
        #1 chk("R2", "level1 at 0", trig_hit, 0);
        push(8'h20, 3'b000);
        chk("R2", "level1 at 1", trig_hit, 1);
        clear_q();
        trig_code = 2'd2;
        for (int i = 0; i < 7; i++) push(8'(i), 3'b000);
        chk("R2", "level8 at 7", trig_hit, 0);
        push(8'h07, 3'b000);
        chk("R2", "level8 at 8", trig_hit, 1);
        trig_code = 2'd3;
        for (int i = 0; i < 5; i++) push(8'(i), 3'b000);
        chk("R2", "level14 at 13", trig_hit, 0);
        push(8'h0D, 3'b000);
        chk("R2", "level14 at 14", trig_hit, 1);
        clear_q();

        // R6: flow control at level 4
        trig_code = 2'd1; afc_en = 1; rts_force = 1;
        tick();
        chk("R6", "asserted when empty", rts, 1);
        for (int i = 0; i < 4; i++) push(8'h40 + 8'(i), 3'b000);
        tick();
        chk("R6", "held at level without start", rts, 1);
        start_seen = 1; tick();
        chk("R6", "dropped on start at level", rts, 0);
        pop();
        chk("R6", "still low in pop cycle", rts, 0);
        tick();
        chk("R6", "restored below level", rts, 1);
        start_seen = 1; tick();
        chk("R6", "start below level keeps", rts, 1);
        rts_force = 0; tick();
        chk("R6", "force clear", rts, 0);
        rts_force = 1; afc_en = 0; tick();
        chk("R6", "force without afc", rts, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule